// File: doc/BRIEF.md
# Station-Management Status Register with Override Gating

This block holds the management-side state of a PHY's basic status register and the extended-control register that gates host access to it. A station-management host reaches both through a flat port: an address, a write strobe with write data, and a read strobe. Read data follows the address combinationally, so the host samples it in the same cycle it raises the read strobe. The serial management framing sits in front of this block, and the negotiation engine sits behind it.

Most status bits are read-only views of live PHY state. A group of five normally reserved bits, status bits 10 to 6, can only be written while the override bit (bit 15 of the extended-control register) is 1. Bit 6 of that group advertises that management frames without a preamble are accepted. It resets to 0 for compatibility with older hosts. The block drives it out so the management framer can act on it.

Status bit 5 reports that negotiation is complete. It is a latch-high bit: it is set by the negotiation engine's completion signal and is held until the host reads the status register. It always reads 0 while negotiation is disabled.

Top module: `mstat_status_regs`

## Requirements
- R1: After reset, status bits 10:6 read 0, `preamble_suppress_en_o` is 0, the extended-control register (address 16) reads 0x0000, and status bit 5 reads 0.
- R2: While bit 15 of register 16 is 0, a write to address 1 leaves status bits 10:6 and `preamble_suppress_en_o` unchanged.
- R3: While bit 15 of register 16 is 1, a write to address 1 loads write-data bits 10:6 into status bits 10:6. The new value is visible from the next cycle.
- R4: `preamble_suppress_en_o` always equals stored status bit 6.
- R5: Register 16 is 16 bits of read/write storage. A write is visible from the next cycle, and bit 15 is the override-enable bit.
- R6: Status bit 5 reads 0 in every cycle in which `an_enable_i` is 0. A cycle with `an_enable_i` at 0 also clears the latched value.
- R7: With `an_enable_i` at 1, status bit 5 reads 1 from the cycle after `an_complete_i` is sampled at 1, and not earlier.
- R8: Once set, status bit 5 stays 1 after `an_complete_i` drops, until a read strobe to address 1. From the following cycle it reads 0, unless `an_complete_i` was 1 in the read cycle.
- R9: Status bits 15:11 and 4:0 equal the same bits of `hw_status_i`. Writes to them have no effect, and `hw_status_i` bits 10:5 never appear at the output.
- R10: A read of any address other than 1 or 16 returns 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mgmt_addr | input | 5 | Register address |
| mgmt_we | input | 1 | Write strobe, one cycle per write |
| mgmt_wdata | input | 16 | Write data |
| mgmt_re | input | 1 | Read strobe, clears the latch-high bit |
| mgmt_rdata | output | 16 | Read data for `mgmt_addr`, combinational |
| hw_status_i | input | 16 | Live read-only status bits from the PHY |
| an_enable_i | input | 1 | Negotiation enabled |
| an_complete_i | input | 1 | Negotiation engine reports completion |
| preamble_suppress_en_o | output | 1 | Preamble-less frame acceptance enabled (status bit 6) |

## Verification
The assertions assume that `mgmt_addr`, the strobes and the negotiation inputs are stable for a whole clock cycle, and that they change only between sampling edges. The bench meets this by driving every input on the falling edge. The assertions also assume a read strobe is meaningful only at address 1; the bench sends strobes to every address, so strobes elsewhere must have no effect. Random stimulus mixes writes, reads, and negotiation-input toggles freely within these rules. Directed sequences then hit the latch corner cases: a read while completion is still high, and a disable without a read.

// File: rtl/mstat_pkg.sv
package mstat_pkg;
   localparam int unsigned MGMT_ADDR_W = 5;
   localparam int unsigned MGMT_DATA_W = 16;

   typedef enum logic [1:0] {
      SEL_NONE   = 2'd0,
      SEL_STATUS = 2'd1,
      SEL_EXTCTL = 2'd2
   } reg_sel_e;
endpackage

// File: rtl/mstat_decode.sv
module mstat_decode
   import mstat_pkg::*;
#(
   parameter int unsigned ADDR_W      = MGMT_ADDR_W,
   parameter int unsigned STATUS_ADDR = 1,
   parameter int unsigned EXTCTL_ADDR = 16
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   input  logic              re,
   output reg_sel_e          sel,
   output logic              wr_status,
   output logic              wr_extctl,
   output logic              rd_status
);
   localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(STATUS_ADDR);
   localparam logic [ADDR_W-1:0] A_EXTCTL = ADDR_W'(EXTCTL_ADDR);

   always_comb begin
      if (addr == A_STATUS)      sel = SEL_STATUS;
      else if (addr == A_EXTCTL) sel = SEL_EXTCTL;
      else                       sel = SEL_NONE;
   end

   assign wr_status = we && (sel == SEL_STATUS);
   assign wr_extctl = we && (sel == SEL_EXTCTL);
   assign rd_status = re && (sel == SEL_STATUS);
endmodule

// File: rtl/mstat_ovr_field.sv
module mstat_ovr_field #(
   parameter int unsigned GRP_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             ovr_en,
   input  logic [GRP_W-1:0] wdata,
   output logic [GRP_W-1:0] grp_q
);
   logic bit_q [GRP_W];

   for (genvar i = 0; i < GRP_W; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                bit_q[i] <= 1'b0;
         else if (wr_en && ovr_en)  bit_q[i] <= wdata[i];
      end
      assign grp_q[i] = bit_q[i];
   end
endmodule

// File: rtl/mstat_anc_latch.sv
module mstat_anc_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic an_en,
   input  logic an_done,
   input  logic rd_clr,
   output logic latched_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       latched_q <= 1'b0;
      else if (!an_en)  latched_q <= 1'b0;
      else if (an_done) latched_q <= 1'b1;
      else if (rd_clr)  latched_q <= 1'b0;
   end
endmodule

// File: rtl/mstat_extctl.sv
module mstat_extctl #(
   parameter int unsigned           DATA_W    = 16,
   parameter int unsigned           CTL_BIT   = 15,
   parameter bit                    STORE_ALL = 1'b1,
   parameter logic [DATA_W-1:0]     RST_VAL   = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] reg_q,
   output logic              ovr_en
);
   localparam logic [DATA_W-1:0] RST_EFF = RST_VAL & ~(DATA_W'(1) << CTL_BIT);

   if (STORE_ALL) begin : g_full
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     reg_q <= RST_EFF;
         else if (wr_en) reg_q <= wdata;
      end
   end else begin : g_ctl_only
      logic ctl_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     ctl_q <= 1'b0;
         else if (wr_en) ctl_q <= wdata[CTL_BIT];
      end
      assign reg_q = DATA_W'(ctl_q) << CTL_BIT;
   end

   assign ovr_en = reg_q[CTL_BIT];
endmodule

// File: rtl/mstat_status_regs.sv
module mstat_status_regs
   import mstat_pkg::*;
#(
   parameter int unsigned       ADDR_W        = MGMT_ADDR_W,
   parameter int unsigned       DATA_W        = MGMT_DATA_W,
   parameter int unsigned       STATUS_ADDR   = 1,
   parameter int unsigned       EXTCTL_ADDR   = 16,
   parameter int unsigned       OVR_CTL_BIT   = 15,
   parameter int unsigned       GRP_LO        = 6,
   parameter int unsigned       GRP_HI        = 10,
   parameter int unsigned       PSUP_BIT      = 6,
   parameter int unsigned       ANC_BIT       = 5,
   parameter bit                EXT_STORE_ALL = 1'b1,
   parameter logic [DATA_W-1:0] EXT_RST_VAL   = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] mgmt_addr,
   input  logic              mgmt_we,
   input  logic [DATA_W-1:0] mgmt_wdata,
   input  logic              mgmt_re,
   output logic [DATA_W-1:0] mgmt_rdata,
   input  logic [DATA_W-1:0] hw_status_i,
   input  logic              an_enable_i,
   input  logic              an_complete_i,
   output logic              preamble_suppress_en_o
);
   localparam int unsigned       GRP_W    = GRP_HI - GRP_LO + 1;
   localparam logic [DATA_W-1:0] ONE      = DATA_W'(1);
   localparam logic [DATA_W-1:0] GRP_MASK = ((ONE << GRP_W) - ONE) << GRP_LO;
   localparam logic [DATA_W-1:0] ANC_MASK = ONE << ANC_BIT;
   localparam logic [DATA_W-1:0] RO_MASK  = ~(GRP_MASK | ANC_MASK);

   if (GRP_HI >= DATA_W || GRP_LO > GRP_HI) begin : g_bad_grp
      $error("override group out of range");
   end
   if (PSUP_BIT < GRP_LO || PSUP_BIT > GRP_HI) begin : g_bad_psup
      $error("preamble-suppression bit must lie in the override group");
   end
   if (ANC_BIT >= DATA_W || (ANC_BIT >= GRP_LO && ANC_BIT <= GRP_HI)) begin : g_bad_anc
      $error("negotiation-complete bit must lie outside the override group");
   end
   if (OVR_CTL_BIT >= DATA_W || STATUS_ADDR == EXTCTL_ADDR
       || STATUS_ADDR >= (1 << ADDR_W) || EXTCTL_ADDR >= (1 << ADDR_W)) begin : g_bad_map
      $error("register map parameters invalid");
   end

   reg_sel_e          sel;
   logic              wr_status, wr_extctl, rd_status;
   logic [DATA_W-1:0] ext_q;
   logic              ovr_en;
   logic [GRP_W-1:0]  grp_bits;
   logic              anc_q;
   logic              anc_rd;
   logic [DATA_W-1:0] status_word;

   mstat_decode #(
      .ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR), .EXTCTL_ADDR(EXTCTL_ADDR)
   ) dec_i (
      .addr(mgmt_addr), .we(mgmt_we), .re(mgmt_re),
      .sel(sel), .wr_status(wr_status), .wr_extctl(wr_extctl), .rd_status(rd_status)
   );

   mstat_extctl #(
      .DATA_W(DATA_W), .CTL_BIT(OVR_CTL_BIT),
      .STORE_ALL(EXT_STORE_ALL), .RST_VAL(EXT_RST_VAL)
   ) ext_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_extctl), .wdata(mgmt_wdata),
      .reg_q(ext_q), .ovr_en(ovr_en)
   );

   mstat_ovr_field #(.GRP_W(GRP_W)) grp_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_status), .ovr_en(ovr_en),
      .wdata(mgmt_wdata[GRP_HI:GRP_LO]), .grp_q(grp_bits)
   );

   mstat_anc_latch anc_i (
      .clk(clk), .rst_n(rst_n), .an_en(an_enable_i), .an_done(an_complete_i),
      .rd_clr(rd_status), .latched_q(anc_q)
   );

   assign anc_rd = an_enable_i && anc_q;

   always_comb begin
      status_word = (hw_status_i & RO_MASK) | (DATA_W'(grp_bits) << GRP_LO);
      if (anc_rd) status_word = status_word | ANC_MASK;
   end

   always_comb begin
      unique case (sel)
         SEL_STATUS: mgmt_rdata = status_word;
         SEL_EXTCTL: mgmt_rdata = ext_q;
         default:    mgmt_rdata = '0;
      endcase
   end

   assign preamble_suppress_en_o = grp_bits[PSUP_BIT - GRP_LO];
endmodule

// File: rtl/mstat_chk.sv
module mstat_chk #(
   parameter int unsigned ADDR_W      = 5,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned STATUS_ADDR = 1,
   parameter int unsigned EXTCTL_ADDR = 16,
   parameter int unsigned PSUP_BIT    = 6,
   parameter int unsigned ANC_BIT     = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] mgmt_addr,
   input logic              mgmt_we,
   input logic              mgmt_re,
   input logic [DATA_W-1:0] mgmt_wdata,
   input logic [DATA_W-1:0] mgmt_rdata,
   input logic              an_enable_i,
   input logic              an_complete_i,
   input logic              preamble_suppress_en_o,
   input logic              ovr_en
);
   localparam logic [ADDR_W-1:0] A_ST = ADDR_W'(STATUS_ADDR);
   localparam logic [ADDR_W-1:0] A_EX = ADDR_W'(EXTCTL_ADDR);

   assert_grp_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mgmt_we && mgmt_addr == A_ST && !ovr_en) |=> $stable(preamble_suppress_en_o));

   assert_grp_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mgmt_we && mgmt_addr == A_ST && ovr_en)
      |=> (preamble_suppress_en_o == $past(mgmt_wdata[PSUP_BIT])));

   assert_ctl_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(mgmt_we && mgmt_addr == A_EX) |=> $stable(ovr_en));

   assert_anc_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mgmt_addr == A_ST && !an_enable_i) |-> !mgmt_rdata[ANC_BIT]);

   assert_anc_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (an_enable_i && an_complete_i)
      |=> (!an_enable_i || mgmt_addr != A_ST || mgmt_rdata[ANC_BIT]));

   assert_anc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (an_enable_i && mgmt_addr == A_ST && mgmt_rdata[ANC_BIT] && !mgmt_re)
      |=> (!an_enable_i || mgmt_addr != A_ST || mgmt_rdata[ANC_BIT]));

   assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mgmt_addr != A_ST && mgmt_addr != A_EX) |-> (mgmt_rdata == '0));
endmodule

bind mstat_status_regs mstat_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STATUS_ADDR(STATUS_ADDR),
   .EXTCTL_ADDR(EXTCTL_ADDR), .PSUP_BIT(PSUP_BIT), .ANC_BIT(ANC_BIT)
) chk_i (
   .clk(clk), .rst_n(rst_n), .mgmt_addr(mgmt_addr), .mgmt_we(mgmt_we),
   .mgmt_re(mgmt_re), .mgmt_wdata(mgmt_wdata), .mgmt_rdata(mgmt_rdata),
   .an_enable_i(an_enable_i), .an_complete_i(an_complete_i),
   .preamble_suppress_en_o(preamble_suppress_en_o), .ovr_en(ovr_en)
);

// File: tb/mstat_status_regs_tb_top.sv
module mstat_status_regs_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  addr = '0;
   logic        we = 1'b0, re = 1'b0;
   logic [15:0] wdata = '0, hw = '0;
   logic        an_en = 1'b0, an_cmp = 1'b0;
   logic [15:0] rdata;
   logic        psup;

   int vectors = 0;
   int miscompares = 0;

   logic [4:0]  m_grp;
   logic [15:0] m_ext;
   logic        m_anc;

   always #5 clk = ~clk;

   mstat_status_regs dut_i (
      .clk(clk), .rst_n(rst_n), .mgmt_addr(addr), .mgmt_we(we),
      .mgmt_wdata(wdata), .mgmt_re(re), .mgmt_rdata(rdata),
      .hw_status_i(hw), .an_enable_i(an_en), .an_complete_i(an_cmp),
      .preamble_suppress_en_o(psup)
   );

   function automatic logic [15:0] exp_rd(logic [4:0] a, logic [15:0] h, logic en);
      logic [15:0] r;
      if (a == 5'd1) begin
         r = h & ~16'h07E0;
         r[10:6] = m_grp;
         r[5] = en & m_anc;
      end else if (a == 5'd16) begin
         r = m_ext;
      end else begin
         r = 16'h0000;
      end
      return r;
   endfunction

   task automatic chk(logic [15:0] act, logic [15:0] exp, string tag);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // One cycle: drive on the falling edge, check before the rising edge, advance model.
   task automatic step(logic s_we, logic s_re, logic [4:0] s_a, logic [15:0] s_wd,
                       logic s_en, logic s_cmp, logic [15:0] s_hw, string tag);
      @(negedge clk);
      we = s_we; re = s_re; addr = s_a; wdata = s_wd;
      an_en = s_en; an_cmp = s_cmp; hw = s_hw;
      #1;
      chk(rdata, exp_rd(s_a, s_hw, s_en), tag);
      chk({15'd0, psup}, {15'd0, m_grp[0]}, "R4 preamble output");
      if (s_we && s_a == 5'd1 && m_ext[15]) m_grp = s_wd[10:6];
      if (s_we && s_a == 5'd16) m_ext = s_wd;
      if (!s_en)                     m_anc = 1'b0;
      else if (s_cmp)                m_anc = 1'b1;
      else if (s_re && s_a == 5'd1)  m_anc = 1'b0;
   endtask

   initial begin
      #200us;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      m_grp = '0; m_ext = '0; m_anc = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      step(0, 0, 5'd1,  16'h0, 0, 0, 16'h0000, "R1 status after reset");
      step(0, 0, 5'd16, 16'h0, 0, 0, 16'h0000, "R1 extctl after reset");
      // R2 override off: write ignored
      step(1, 0, 5'd1,  16'hFFFF, 0, 0, 16'h0000, "R2 write locked");
      step(0, 0, 5'd1,  16'h0, 0, 0, 16'h0000, "R2 group still zero");
      // R5 extctl storage, bit15 sets override
      step(1, 0, 5'd16, 16'h8A5C, 0, 0, 16'h0000, "R5 extctl write");
      step(0, 0, 5'd16, 16'h0, 0, 0, 16'h0000, "R5 extctl readback");
      // R3/R4 override write
      step(1, 0, 5'd1,  16'h07C0, 0, 0, 16'h0000, "R3 write group");
      step(0, 0, 5'd1,  16'h0, 0, 0, 16'h0000, "R3 group readback ones");
      step(1, 0, 5'd1,  16'h0040, 0, 0, 16'h0000, "R3 write psup only");
      step(0, 0, 5'd1,  16'h0, 0, 0, 16'h0000, "R4 psup set");
      // R9 read-only bits from hw; write to them dropped
      step(1, 0, 5'd1,  16'hF83F, 0, 0, 16'hFFFF, "R9 hw bits, write dropped");
      step(0, 0, 5'd1,  16'h0, 0, 0, 16'hA815, "R9 hw pattern");
      // R10 unmapped addresses
      step(0, 1, 5'd0,  16'h0, 0, 0, 16'hFFFF, "R10 addr 0");
      step(0, 0, 5'd2,  16'h0, 0, 0, 16'hFFFF, "R10 addr 2");
      step(0, 0, 5'd17, 16'h0, 0, 0, 16'hFFFF, "R10 addr 17");
      step(0, 0, 5'd31, 16'h0, 0, 0, 16'hFFFF, "R10 addr 31");
      // R6 disabled reads zero even with completion
      step(0, 0, 5'd1,  16'h0, 0, 1, 16'h0000, "R6 disabled");
      step(0, 0, 5'd1,  16'h0, 0, 1, 16'h0000, "R6 disabled again");
      // R7 set one cycle after completion
      step(0, 0, 5'd1,  16'h0, 1, 1, 16'h0000, "R7 not yet set");
      step(0, 0, 5'd1,  16'h0, 1, 0, 16'h0000, "R7 set after completion");
      // R8 hold, read clears next cycle
      step(0, 0, 5'd1,  16'h0, 1, 0, 16'h0000, "R8 held");
      step(0, 1, 5'd1,  16'h0, 1, 0, 16'h0000, "R8 read returns one");
      step(0, 0, 5'd1,  16'h0, 1, 0, 16'h0000, "R8 cleared after read");
      // R8 read while completion still high keeps it set
      step(0, 0, 5'd1,  16'h0, 1, 1, 16'h0000, "R8 set again");
      step(0, 1, 5'd1,  16'h0, 1, 1, 16'h0000, "R8 read with completion high");
      step(0, 0, 5'd1,  16'h0, 1, 0, 16'h0000, "R8 survives read");
      // R6 disable clears latch without read
      step(0, 0, 5'd1,  16'h0, 0, 0, 16'h0000, "R6 disable clears");
      step(0, 0, 5'd1,  16'h0, 1, 0, 16'h0000, "R6 re-enable reads zero");
      // R2 drop override and write zeros: group must stay
      step(1, 0, 5'd16, 16'h0123, 1, 0, 16'h0000, "R5 clear override");
      step(1, 0, 5'd1,  16'h0000, 1, 0, 16'h0000, "R2 locked write zeros");
      step(0, 0, 5'd1,  16'h0, 1, 0, 16'h0000, "R2 group kept");

      // Constrained random mix
      for (int i = 0; i < 600; i++) begin
         logic [4:0]  ra;
         logic [2:0]  pick;
         pick = 3'($urandom_range(0, 7));
         case (pick)
            3'd0, 3'd1: ra = 5'd1;
            3'd2:       ra = 5'd16;
            default:    ra = ($urandom_range(0, 3) == 0) ? 5'($urandom) : 5'd1;
         endcase
         step($urandom_range(0, 3) == 0, $urandom_range(0, 2) == 0, ra,
              16'($urandom), $urandom_range(0, 5) != 0, $urandom_range(0, 3) == 0,
              16'($urandom), "R3 R5 R8 R9 random");
      end

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule